// File: doc/BRIEF.md
# Byte-Serial String and Block Memory Engine

This unit runs one of five C-library style memory routines on its own, touching memory one byte per transfer over a narrow request/acknowledge port. The routines are block copy, block fill, string length, string compare and string copy. The string copy variant returns a pointer to the terminator it wrote. A processor or a sequencer loads an operation code and three 32-bit operands and pulses `start`. It then waits for a single-cycle `done`, at which point `result` holds the answer.

Operands depend on the operation. Block copy takes source in `opnd_a`, length in `opnd_b` and destination in `opnd_d`. Block fill takes the value in `opnd_a`, length in `opnd_b` and destination in `opnd_d`. String length takes the string in `opnd_a`. String compare takes string A in `opnd_a` and string B in `opnd_b`. String copy takes source in `opnd_a` and destination in `opnd_d`. Only the low 15 bits of a block length count. Every read that feeds a write is acknowledged before that write is requested.

Top module: `strmem_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0 and `result` is 0.
- R2: Operation code 0 (block copy) copies the masked length of bytes from `opnd_a` to `opnd_d` in ascending address order. For each byte it reads the source and then writes the destination. `result` is the masked length.
- R3: Operation code 1 (block fill) writes `opnd_a[7:0]` to the masked length of consecutive bytes starting at `opnd_d`, with no reads. `result` is the masked length.
- R4: The block length is `opnd_b & 0x7FFF`, so bits 31..15 of `opnd_b` have no effect on copy or fill.
- R5: A copy or fill with a masked length of zero makes no memory access and raises `done` in the cycle after `start` is taken, with `result` 0.
- R6: Operation code 2 (string length) reads from `opnd_a` upward until it reads a zero byte. `result` is the number of bytes read before that zero.
- R7: Operation code 3 (string compare) reads byte A then byte B at each index. It moves on while A is nonzero and equal to B. `result` is the 9-bit unsigned byte difference A-B at the stopping index, sign-extended to 32 bits.
- R8: Operation code 4 (string copy) copies source bytes to the destination up to and including the first zero byte. `result` is `opnd_d` plus the number of nonzero bytes copied.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values in the next cycle. Each acknowledge completes exactly one byte access.
- R10: `done` is high for exactly one cycle per operation. `result` holds its value until the next accepted start. A `start` while `busy` is high is ignored.
- R11: Operation codes 5 to 7 make no memory access and raise `done` in the cycle after `start`, with `result` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code: 0 copy, 1 fill, 2 length, 3 compare, 4 string copy |
| opnd_a | input | 32 | Source address, string A address, or fill value |
| opnd_b | input | 32 | Block length or string B address |
| opnd_d | input | 32 | Destination address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 8 | Read byte |

## Verification
The hardest case to reach from the ports is a `start` that arrives while an access is still stalled waiting for its acknowledge. A correct engine must drop that request without disturbing the access in flight. The bench stretches the acknowledge latency of its memory model to several cycles, launches a string-length run and then pulses `start` with a fill request partway through. It checks that the fill target is untouched and that the length result comes out intact. Compare results whose sign bit depends on a 0xFF byte against a zero byte are driven from the vector table to exercise the 9-bit sign extension.

// File: rtl/strmem_pkg.sv
package strmem_pkg;
  localparam int RES_W = 32;

  localparam logic [2:0] OP_COPY = 3'd0;
  localparam logic [2:0] OP_FILL = 3'd1;
  localparam logic [2:0] OP_SLEN = 3'd2;
  localparam logic [2:0] OP_SCMP = 3'd3;
  localparam logic [2:0] OP_SCPY = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD_A = 3'd1,
    ST_RD_B = 3'd2,
    ST_WR   = 3'd3,
    ST_FIN  = 3'd4
  } state_e;

  // unsigned byte difference, 9-bit result sign-extended to RES_W
  function automatic logic [RES_W-1:0] byte_diff(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] d;
    d = {1'b0, a} - {1'b0, b};
    return {{(RES_W-9){d[8]}}, d};
  endfunction
endpackage

// File: rtl/strmem_port.sv
module strmem_port #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_base,
  input  logic [ADDR_W-1:0] acc_idx,
  input  logic [7:0]        acc_wbyte,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              xfer
);
  assign mem_req   = acc_req;
  assign mem_we    = acc_req & acc_we;
  assign mem_addr  = acc_base + acc_idx;
  assign mem_wdata = acc_we ? acc_wbyte : 8'h00;
  assign xfer      = acc_req & mem_ack;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/strmem_ctrl.sv
module strmem_ctrl
  import strmem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [31:0]       opnd_a,
  input  logic [31:0]       opnd_b,
  input  logic [31:0]       opnd_d,
  input  logic              xfer,
  input  logic [7:0]        rdata,
  output logic              acc_req,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_base,
  output logic [ADDR_W-1:0] acc_idx,
  output logic [7:0]        acc_wbyte,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  state_e            st;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] pa, pb, pd, idx;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        fill_q, byte_a;

  // named events
  logic             start_acc, rd_a_done, rd_b_done, wr_done;
  logic             blk_last, cmp_stop, known_op;
  logic [LEN_W-1:0] len_in;

  assign len_in    = opnd_b[LEN_W-1:0];
  assign start_acc = start && (st == ST_IDLE);
  assign known_op  = (op <= OP_SCPY);
  assign rd_a_done = xfer && (st == ST_RD_A);
  assign rd_b_done = xfer && (st == ST_RD_B);
  assign wr_done   = xfer && (st == ST_WR);
  assign blk_last  = (idx[LEN_W-1:0] + LEN_W'(1)) == len_q;
  assign cmp_stop  = (byte_a == 8'h00) || (byte_a != rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= 3'd0;
      pa     <= '0;
      pb     <= '0;
      pd     <= '0;
      idx    <= '0;
      len_q  <= '0;
      fill_q <= 8'h00;
      byte_a <= 8'h00;
      result <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q   <= op;
          pa     <= opnd_a[ADDR_W-1:0];
          pb     <= opnd_b[ADDR_W-1:0];
          pd     <= opnd_d[ADDR_W-1:0];
          len_q  <= len_in;
          fill_q <= opnd_a[7:0];
          idx    <= '0;
          result <= '0;
          if (!known_op)                          st <= ST_FIN;
          else if (op == OP_FILL)                 st <= (len_in == '0) ? ST_FIN : ST_WR;
          else if (op == OP_COPY && len_in == '0) st <= ST_FIN;
          else                                    st <= ST_RD_A;
        end
        ST_RD_A: if (xfer) begin
          byte_a <= rdata;
          if (op_q == OP_SCMP) st <= ST_RD_B;
          else if (op_q == OP_SLEN) begin
            if (rdata == 8'h00) begin
              result <= RES_W'(idx);
              st     <= ST_FIN;
            end else idx <= idx + 1'b1;
          end else st <= ST_WR;
        end
        ST_RD_B: if (xfer) begin
          if (cmp_stop) begin
            result <= byte_diff(byte_a, rdata);
            st     <= ST_FIN;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_RD_A;
          end
        end
        ST_WR: if (xfer) begin
          if (op_q == OP_SCPY) begin
            if (byte_a == 8'h00) begin
              result <= RES_W'(pd + idx);
              st     <= ST_FIN;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_RD_A;
            end
          end else if (blk_last) begin
            result <= RES_W'(len_q);
            st     <= ST_FIN;
          end else begin
            idx <= idx + 1'b1;
            st  <= (op_q == OP_FILL) ? ST_WR : ST_RD_A;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign acc_req   = (st == ST_RD_A) || (st == ST_RD_B) || (st == ST_WR);
  assign acc_we    = (st == ST_WR);
  assign acc_base  = (st == ST_RD_A) ? pa : (st == ST_RD_B) ? pb : pd;
  assign acc_idx   = idx;
  assign acc_wbyte = (op_q == OP_FILL) ? fill_q : byte_a;
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_FIN);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && (op == OP_COPY || op == OP_FILL) && len_in == '0) |=> (done && result == '0));
  // R11
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && !known_op) |=> (done && result == '0 && !acc_req));
  // R6
  slen_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_done && op_q == OP_SLEN && rdata == 8'h00) |=> (done && result == RES_W'($past(idx))));
  // R2
  copy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_done && op_q == OP_COPY) |=> (acc_we && acc_idx == $past(acc_idx)));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || !busy) |-> !acc_req);
  // R3
  fill_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_FILL && acc_req) |-> acc_we);
  // R8
  scpy_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && op_q == OP_SCPY && byte_a == 8'h00) |=> done);
endmodule

// File: rtl/strmem_engine.sv
module strmem_engine
  import strmem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [31:0]       opnd_a,
  input  logic [31:0]       opnd_b,
  input  logic [31:0]       opnd_d,
  output logic              busy,
  output logic              done,
  output logic [31:0]       result,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);
  logic              acc_req, acc_we, xfer;
  logic [ADDR_W-1:0] acc_base, acc_idx;
  logic [7:0]        acc_wbyte;

  strmem_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_d(opnd_d),
    .xfer(xfer), .rdata(mem_rdata),
    .acc_req(acc_req), .acc_we(acc_we), .acc_base(acc_base),
    .acc_idx(acc_idx), .acc_wbyte(acc_wbyte),
    .busy(busy), .done(done), .result(result)
  );

  strmem_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_base(acc_base), .acc_idx(acc_idx), .acc_wbyte(acc_wbyte),
    .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .xfer(xfer)
  );
endmodule

// File: tb/strmem_engine_bench.sv
module strmem_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_d = '0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] result, mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'h00;

  int total = 0, bad = 0;
  logic [7:0] mem [256];
  int lat = 0, wait_c = 0, acc_n = 0, wr_n = 0, viol = 0;
  int wr_log [64];
  logic prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  always #4 clk = ~clk;

  strmem_engine u_strmem_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_d(opnd_d),
    .busy(busy), .done(done), .result(result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model with programmable acknowledge latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wait_c  <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wait_c >= lat) begin
        mem_ack <= 1'b1;
        wait_c  <= 0;
        acc_n   <= acc_n + 1;
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          if (wr_n < 64) wr_log[wr_n] <= int'(mem_addr[7:0]);
          wr_n <= wr_n + 1;
        end else mem_rdata <= mem[mem_addr[7:0]];
      end else wait_c <= wait_c + 1;
    end else mem_ack <= 1'b0;
  end

  // handshake monitor (R9)
  always @(posedge clk) begin
    if (rst_n && prev_pend && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
    prev_pend <= rst_n && mem_req && !mem_ack;
    prev_addr <= mem_addr;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] d, output logic [31:0] res, output int cyc,
                        output bit pulse_ok);
    @(negedge clk);
    start = 1'b1; op = o; opnd_a = a; opnd_b = b; opnd_d = d;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    res = result;
    @(negedge clk);
    pulse_ok = !done && (result == res);
  endtask

  typedef struct packed {
    logic [2:0]  o;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd2, 32'h10, 32'h0,  32'h0000_0003},
    '{3'd2, 32'h40, 32'h0,  32'h0000_0000},
    '{3'd3, 32'h10, 32'h20, 32'hFFFF_FFFF},
    '{3'd3, 32'h10, 32'h30, 32'h0000_0000},
    '{3'd3, 32'h20, 32'h10, 32'h0000_0001},
    '{3'd3, 32'h50, 32'h40, 32'h0000_00FF},
    '{3'd3, 32'h40, 32'h50, 32'hFFFF_FF01},
    '{3'd2, 32'h50, 32'h0,  32'h0000_0001}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] res;
    int cyc, a0, w0;
    bit pok;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    mem[8'h10] = 8'h61; mem[8'h11] = 8'h62; mem[8'h12] = 8'h63; mem[8'h13] = 8'h00;
    mem[8'h20] = 8'h61; mem[8'h21] = 8'h62; mem[8'h22] = 8'h64; mem[8'h23] = 8'h00;
    mem[8'h30] = 8'h61; mem[8'h31] = 8'h62; mem[8'h32] = 8'h63; mem[8'h33] = 8'h00;
    mem[8'h40] = 8'h00;
    mem[8'h50] = 8'hFF; mem[8'h51] = 8'h00;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req, "R1 idle outputs", {29'd0, busy, done, mem_req}, 32'h0);
    chk(result == 32'h0, "R1 result", result, 32'h0);
    rst_n = 1'b1;

    // table: string length (R6) and compare (R7), varying latency
    for (int i = 0; i < 8; i++) begin
      lat = i % 3;
      run_op(VECS[i].o, VECS[i].a, VECS[i].b, 32'h0, res, cyc, pok);
      chk(res == VECS[i].exp, (VECS[i].o == 3'd2) ? "R6 length" : "R7 compare", res, VECS[i].exp);
      chk(pok, "R10 single done pulse", {31'd0, pok}, 32'h1);
    end

    // R7 access pattern: abc vs abd reads A,B at three indices
    lat = 1;
    a0 = acc_n;
    run_op(3'd3, 32'h10, 32'h20, 32'h0, res, cyc, pok);
    chk(acc_n - a0 == 6, "R7 access count", acc_n - a0, 6);

    // R2 copy, ascending order
    lat = 2;
    a0 = acc_n; w0 = wr_n;
    run_op(3'd0, 32'h10, 32'h3, 32'h80, res, cyc, pok);
    chk(res == 32'h3, "R2 copy result", res, 32'h3);
    chk({mem[8'h80], mem[8'h81], mem[8'h82]} == 24'h616263, "R2 copy data",
        {8'h0, mem[8'h80], mem[8'h81], mem[8'h82]}, 32'h616263);
    chk(mem[8'h83] == 8'hEE, "R2 copy bound", mem[8'h83], 8'hEE);
    chk(wr_log[w0] == 8'h80 && wr_log[w0+1] == 8'h81 && wr_log[w0+2] == 8'h82,
        "R2 ascending order", wr_log[w0+2], 32'h82);
    chk(acc_n - a0 == 6, "R2 read+write count", acc_n - a0, 6);

    // R3/R4 fill with upper length bits set
    lat = 0;
    a0 = acc_n;
    run_op(3'd1, 32'h1234_56A5, 32'h0001_8004, 32'h90, res, cyc, pok);
    chk(res == 32'h4, "R4 masked length", res, 32'h4);
    chk({mem[8'h90], mem[8'h91], mem[8'h92], mem[8'h93]} == 32'hA5A5A5A5, "R3 fill data",
        {mem[8'h90], mem[8'h91], mem[8'h92], mem[8'h93]}, 32'hA5A5A5A5);
    chk(mem[8'h94] == 8'hEE, "R4 fill bound", mem[8'h94], 8'hEE);
    chk(acc_n - a0 == 4, "R3 no reads", acc_n - a0, 4);

    // R5 zero length after mask
    a0 = acc_n;
    run_op(3'd0, 32'h10, 32'h0000_8000, 32'hB0, res, cyc, pok);
    chk(cyc == 1, "R5 immediate done", cyc, 1);
    chk(acc_n == a0 && res == 0, "R5 no access", acc_n - a0, 0);
    run_op(3'd1, 32'h55, 32'h0, 32'hB0, res, cyc, pok);
    chk(cyc == 1 && acc_n == a0, "R5 fill zero", cyc, 1);

    // R8 string copy
    lat = 1;
    run_op(3'd4, 32'h10, 32'h0, 32'hA0, res, cyc, pok);
    chk(res == 32'hA3, "R8 end pointer", res, 32'hA3);
    chk({mem[8'hA0], mem[8'hA1], mem[8'hA2], mem[8'hA3]} == 32'h61626300, "R8 copied with terminator",
        {mem[8'hA0], mem[8'hA1], mem[8'hA2], mem[8'hA3]}, 32'h61626300);
    chk(mem[8'hA4] == 8'hEE, "R8 bound", mem[8'hA4], 8'hEE);
    run_op(3'd4, 32'h40, 32'h0, 32'hC8, res, cyc, pok);
    chk(res == 32'hC8 && mem[8'hC8] == 8'h00, "R8 empty string", res, 32'hC8);

    // R11 unused codes
    for (int k = 5; k < 8; k++) begin
      a0 = acc_n;
      run_op(3'(k), 32'h10, 32'h5, 32'hB0, res, cyc, pok);
      chk(cyc == 1 && res == 0 && acc_n == a0, "R11 unused op", res, 32'h0);
    end

    // R10 start while busy is ignored
    lat = 3;
    @(negedge clk);
    start = 1'b1; op = 3'd2; opnd_a = 32'h10; opnd_b = 0; opnd_d = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; op = 3'd1; opnd_a = 32'h77; opnd_b = 32'h2; opnd_d = 32'hC0;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(result == 32'h3, "R10 busy start result", result, 32'h3);
    repeat (4) @(negedge clk);
    chk(mem[8'hC0] == 8'hEE && !busy, "R10 busy start ignored", mem[8'hC0], 8'hEE);

    // R9 handshake held across stalls
    chk(viol == 0, "R9 request hold", viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule